// File: doc/BRIEF.md
# Frame bit region tagger

This block follows one configuration frame as it streams past one bit per valid cycle, and labels every bit with the part of the frame it belongs to. A frame is not a plain array of rows. It starts with a small bottom clock-row area and a bottom IOB area. Then come 80 bits for each interconnect row, from the bottom row to the top row. It ends with a top IOB area and a top clock-row area. The block gives, for the bit presented in the current cycle, a region code, the row index and offset within the region, and the clock-row index for clock-row bits. It also gives a pulse on the final bit.

The labels are combinational on the current inputs. A bit presented together with the frame-start pulse is bit 0 of a new frame. A frame-start pulse without a valid bit arms the block so that the next valid bit is bit 0. The block never looks at the bit values. It only counts positions. Parameters set the number of interconnect rows and the number of clock rows in each half, which may be up to 4.

Top module: `frame_region_tagger`

## Requirements
- R1: A frame holds 32 + 80*ROWS valid bits. `frame_end` is 1 only on the last of these bits.
- R2: Regions follow one another in this order: 4 clock-bottom bits (code 0), 12 IOB-bottom bits (code 1), 80*ROWS row bits (code 2), 12 IOB-top bits (code 3), 4 clock-top bits (code 4).
- R3: Bit k (0..3) of the bottom clock area has `clk_row` = k and `offset` = k. Clock row 0 is the row nearest the bottom edge.
- R4: Bit k (0..3) of the top clock area has `clk_row` = k and `offset` = k. Clock row 0 is the row nearest the top edge.
- R5: A clock-area bit k with k >= CLK_ROWS_BOT in the bottom area, or k >= CLK_ROWS_TOP in the top area, reads region code 5 (unused). Every region-5 output has `row_idx`, `offset` and `clk_row` all 0.
- R6: Row bit j of the row area has `row_idx` = j/80 and `offset` = j%80, with row 0 at the bottom.
- R7: IOB bits carry `offset` 0..11 within their area. Outside clock regions `clk_row` is 0, and outside code 2 `row_idx` is 0.
- R8: After the last bit of a frame, valid bits read region 5 with no `frame_end` until the next frame-start pulse.
- R9: A frame-start pulse in the middle of a frame restarts counting. A pulse presented with a valid bit makes that bit bit 0.
- R10: A cycle with `bit_valid` low reads region 5 with `frame_end` 0, and does not advance the position.
- R11: After reset no frame is in progress. Valid bits read region 5 and `frame_end` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Begins a frame; a bit presented together with it is bit 0 |
| bit_valid | input | 1 | A frame bit is presented this cycle |
| region | output | 3 | Region code of the current bit, 0..5 |
| row_idx | output | max(1,clog2(ROWS)) | Interconnect row of the bit (code 2 only) |
| offset | output | 7 | Bit offset within its region or row |
| clk_row | output | 2 | Clock-row index for clock-area bits |
| frame_end | output | 1 | Last bit of the frame |

## Verification
The assertions take for granted that the inputs are settled before each clock edge and that the outputs are read in the same cycle as the bit they describe. They also assume the clock-row parameters are at most 4. The bench changes inputs only on the falling edge and reads the labels one time unit later. It keeps to a configuration of 3 rows with 2 bottom and 3 top clock rows, so that both the used and the unused clock bits occur. Its stimulus places gaps, repeated starts and traffic after the end of a frame only between clock edges.

// File: rtl/frame_region_tagger.sv
module frame_region_tagger #(
  parameter int ROWS = 8,
  parameter int CLK_ROWS_BOT = 4,
  parameter int CLK_ROWS_TOP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic bit_valid,
  output logic [2:0] region,
  output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] row_idx,
  output logic [6:0] offset,
  output logic [1:0] clk_row,
  output logic frame_end
);
  localparam int LEN = 32 + 80 * ROWS;
  localparam int PW = $clog2(LEN);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [PW-1:0] P_IOB_B = PW'(4);
  localparam logic [PW-1:0] P_ROWS = PW'(16);
  localparam logic [PW-1:0] P_IOB_T = PW'(16 + 80 * ROWS);
  localparam logic [PW-1:0] P_CLK_T = PW'(28 + 80 * ROWS);
  localparam logic [PW-1:0] P_LAST = PW'(LEN - 1);
  localparam logic [PW-1:0] N_CB = PW'(CLK_ROWS_BOT);
  localparam logic [PW-1:0] N_CT = PW'(CLK_ROWS_TOP);

  logic [PW-1:0] pos_q;
  logic [RW-1:0] row_q;
  logic [6:0] off_q;
  logic active_q;

  wire [PW-1:0] pos = frame_start ? '0 : pos_q;
  wire [RW-1:0] row_e = frame_start ? '0 : row_q;
  wire [6:0] off_e = frame_start ? '0 : off_q;
  wire tag = bit_valid & (frame_start | active_q);
  wire last = pos == P_LAST;
  wire [PW-1:0] k_top = pos - P_CLK_T;

  assign frame_end = tag & last;

  always_comb begin
    region = 3'd5;
    row_idx = '0;
    offset = '0;
    clk_row = '0;
    if (tag) begin
      if (pos < P_IOB_B) begin
        if (pos < N_CB) begin
          region = 3'd0;
          clk_row = pos[1:0];
          offset = 7'(pos);
        end
      end else if (pos < P_ROWS) begin
        region = 3'd1;
        offset = 7'(pos - P_IOB_B);
      end else if (pos < P_IOB_T) begin
        region = 3'd2;
        row_idx = row_e;
        offset = off_e;
      end else if (pos < P_CLK_T) begin
        region = 3'd3;
        offset = 7'(pos - P_IOB_T);
      end else if (k_top < N_CT) begin
        region = 3'd4;
        clk_row = k_top[1:0];
        offset = 7'(k_top);
      end
    end
  end

  wire in_rows = tag && pos >= P_ROWS && pos < P_IOB_T;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      row_q <= '0;
      off_q <= '0;
      active_q <= 1'b0;
    end else if (tag) begin
      if (last) begin
        pos_q <= '0;
        row_q <= '0;
        off_q <= '0;
        active_q <= 1'b0;
      end else begin
        pos_q <= pos + 1'b1;
        active_q <= 1'b1;
        if (in_rows && off_e == 7'd79) begin
          off_q <= '0;
          row_q <= row_e + 1'b1;
        end else if (in_rows) begin
          off_q <= off_e + 1'b1;
          row_q <= row_e;
        end else begin
          off_q <= off_e;
          row_q <= row_e;
        end
      end
    end else if (frame_start) begin
      pos_q <= '0;
      row_q <= '0;
      off_q <= '0;
      active_q <= 1'b1;
    end
  end

  p_row_bound_r6: assert property (@(posedge clk) disable iff (rst)
    region == 3'd2 |-> (32'(row_idx) < ROWS && offset < 7'd80));

  p_row_step_r6: assert property (@(posedge clk) disable iff (rst)
    (region == 3'd2 && offset != 7'd79) ##1 (bit_valid && !frame_start)
      |-> (region == 3'd2 && offset == $past(offset) + 7'd1));

  p_end_in_top_r1: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (region == 3'd4 || region == 3'd5));

  p_hold_after_end_r8: assert property (@(posedge clk) disable iff (rst)
    frame_end ##1 !frame_start |-> region == 3'd5);

  p_clk_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (region == 3'd0 |-> 32'(clk_row) < CLK_ROWS_BOT) and
    (region == 3'd4 |-> 32'(clk_row) < CLK_ROWS_TOP));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> (region == 3'd5 && !frame_end));
endmodule

// File: tb/frame_region_tagger_test.sv
module frame_region_tagger_test;
  localparam int ROWS = 3;
  localparam int CB = 2;
  localparam int CT = 3;
  localparam int LEN = 32 + 80 * ROWS;

  logic clk = 0, rst = 1, frame_start = 0, bit_valid = 0;
  logic [2:0] region;
  logic [1:0] row_idx;
  logic [6:0] offset;
  logic [1:0] clk_row;
  logic frame_end;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frame_region_tagger #(.ROWS(ROWS), .CLK_ROWS_BOT(CB), .CLK_ROWS_TOP(CT)) uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .bit_valid(bit_valid),
    .region(region), .row_idx(row_idx), .offset(offset), .clk_row(clk_row),
    .frame_end(frame_end));

  function automatic void expect_bit(input int p, output int r, output int ri,
                                     output int of, output int cr);
    int t;
    r = 5; ri = 0; of = 0; cr = 0;
    t = p - (16 + 80 * ROWS);
    if (p < 4) begin
      if (p < CB) begin r = 0; of = p; cr = p; end
    end else if (p < 16) begin
      r = 1; of = p - 4;
    end else if (t < 0) begin
      r = 2; ri = (p - 16) / 80; of = (p - 16) % 80;
    end else if (t < 12) begin
      r = 3; of = t;
    end else if (t - 12 < CT) begin
      r = 4; of = t - 12; cr = t - 12;
    end
  endfunction

  task automatic drive(input logic fs, input logic bv);
    @(negedge clk);
    frame_start = fs;
    bit_valid = bv;
    #1;
  endtask

  task automatic check_bit(input int p);
    int r, ri, of, cr;
    string tg;
    expect_bit(p, r, ri, of, cr);
    case (r)
      0: tg = "R3"; 1: tg = "R7"; 2: tg = "R6"; 3: tg = "R7"; 4: tg = "R4"; default: tg = "R5";
    endcase
    checks++;
    if (int'(region) != r || int'(row_idx) != ri || int'(offset) != of || int'(clk_row) != cr) begin
      errors++;
      $display("FAIL R2 %s bit %0d: got r=%0d row=%0d off=%0d clk=%0d exp r=%0d row=%0d off=%0d clk=%0d",
               tg, p, region, row_idx, offset, clk_row, r, ri, of, cr);
    end
    checks++;
    if (frame_end !== (p == LEN - 1)) begin
      errors++;
      $display("FAIL R1 bit %0d: frame_end=%0b exp %0b", p, frame_end, p == LEN - 1);
    end
  endtask

  task automatic check_idle(input string tg);
    checks++;
    if (region != 3'd5 || frame_end !== 1'b0 || offset != 0 || row_idx != 0 || clk_row != 0) begin
      errors++;
      $display("FAIL %s: got r=%0d end=%0b off=%0d exp r=5 end=0 off=0", tg, region, frame_end, offset);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    drive(0, 1);
    rst = 0;
    for (int i = 0; i < 3; i++) begin drive(0, 1); check_idle("R11 after reset"); end

    for (int i = 0; i < LEN; i++) begin
      if (i % 7 == 3) begin drive(0, 0); check_idle("R10 gap"); end
      drive(i == 0, 1);
      check_bit(i);
    end
    for (int i = 0; i < 4; i++) begin drive(0, 1); check_idle("R8 after end"); end

    drive(1, 0);
    check_idle("R10 start without bit");
    for (int i = 0; i < 100; i++) begin drive(0, 1); check_bit(i); end
    drive(1, 1);
    checks++;
    if (region != 3'd0 || offset != 0) begin
      errors++;
      $display("FAIL R9 restart: got r=%0d off=%0d exp r=0 off=0", region, offset);
    end
    for (int i = 1; i < LEN; i++) begin drive(0, 1); check_bit(i); end
    drive(0, 1);
    check_idle("R8 second end");
    drive(0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule